// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block services translation misses. When the translation cache cannot map a 32-bit virtual address, it hands that address to the walker. The walker uses the physical base address of the root table, which software keeps in a register. It issues two dependent 4-byte reads on a memory port that allows one outstanding read. The first read fetches the root-table entry, which names the frame that holds a leaf table. The second read fetches the leaf-table entry, which names the physical frame of the data page. The walker then reports either the frame number, together with the virtual page number so the cache can refill an entry, or a fault.

The virtual address is divided into three fields. The top ten bits select a root entry, the next ten bits select a leaf entry, and the low twelve bits are the byte offset within a page. Every entry reserves one bit to mark it present. The root table is pinned in physical memory, so it is read at its base plus an index with no translation. Only one walk is in flight at a time, and a new walk is accepted only while the walker is idle.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle. `walkReady` is 1, and `memReqValid` and `resValid` are 0.
- R2: The first read of a walk is at `rootBase + vaddr[31:22]*4`.
- R3: The second read of a walk is at `{rootEntry[31:12], vaddr[21:12], 2'b00}`, where `rootEntry` is the data returned by the first read.
- R4: A read request holds `memReqValid` high with a stable address until `memReqReady` is seen. No new request is raised while a read is awaiting its response.
- R5: A root entry with bit 0 equal to 0 ends the walk after one read, with `resFault`=1 and `resLevel`=0.
- R6: A leaf entry with bit 0 equal to 0 ends the walk after two reads, with `resFault`=1 and `resLevel`=1.
- R7: A leaf entry with bit 0 equal to 1 ends the walk with `resFault`=0 and `resPfn` equal to the leaf entry bits 31:12. Entry bits 11:1 have no effect on the outcome.
- R8: Every result carries `resVpn` equal to `vaddr[31:12]` and `resFaultAddr` equal to the full virtual address of the walk.
- R9: `walkReady` is 0 while a walk is in progress. A `walkValid` raised during that time is ignored and does not alter the result.
- R10: Each walk produces exactly one `resValid` pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| walkValid | input | 1 | A missed address is offered |
| walkReady | output | 1 | Walker is idle and takes the offered address |
| walkVaddr | input | 32 | Virtual address to translate |
| rootBase | input | 32 | Physical base address of the root table |
| memReqValid | output | 1 | Read request pending |
| memReqReady | input | 1 | Memory takes the request this cycle |
| memReqAddr | output | 32 | Physical byte address of the entry to read |
| memRspValid | input | 1 | Read data is returned this cycle |
| memRspData | input | 32 | Entry read from memory |
| resValid | output | 1 | One-cycle result strobe |
| resFault | output | 1 | Walk ended on a non-present entry |
| resLevel | output | 1 | Level of the fault: 0 for the root, 1 for the leaf |
| resVpn | output | 20 | Virtual page number of the walk |
| resPfn | output | 20 | Physical frame number; 0 on a fault |
| resFaultAddr | output | 32 | Full virtual address of the walk |

## Verification
The sweep covers the root indices 0, 1022 and 1023, the leaf indices 0 and 1023, and two table bases. A design that scales the index wrongly or drops the base would read the wrong entry, and the model's address check would flag it. The entries returned by the model carry set bits in positions 11:1, so a walker that copies those bits into the frame, or tests the wrong present bit, reports a wrong frame or a wrong fault. Each walk meets a different mix of request stalls and response latencies. A walker that lets go of its request early, changes the address while stalled, or issues the second read before the first response would trip the model. A second request offered in the middle of a walk must leave the result unchanged, and must never cause a second result pulse.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // Position of the present flag inside every table entry.
  localparam int PRESENT_BIT = 0;

  typedef enum logic [1:0] {
    WALK_IDLE   = 2'd0,
    WALK_ROOT   = 2'd1,
    WALK_LEAF   = 2'd2,
    WALK_REPORT = 2'd3
  } walkState_t;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic capReq;     // latch virtual address and root base, clear result
    logic capTable;   // store leaf-table frame from root entry
    logic capLeaf;    // store data-page frame from leaf entry
    logic faultRoot;  // record fault at the root level
    logic faultLeaf;  // record fault at the leaf level
    logic selLeaf;    // address mux: 0 root entry, 1 leaf entry
  } ptwStrobes_t;

endpackage

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int OFFSET_W   = 12,
  parameter int IDX_W      = 10,
  parameter int ENTRY_LOG2 = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ptwStrobes_t                  strb,
  input  logic [ADDR_W-1:0]            walkVaddr,
  input  logic [ADDR_W-1:0]            rootBase,
  input  logic [ADDR_W-1:0]            memRspData,
  output logic [ADDR_W-1:0]            memReqAddr,
  output logic                         entryPresent,
  output logic                         resFault,
  output logic                         resLevel,
  output logic [ADDR_W-OFFSET_W-1:0]   resVpn,
  output logic [ADDR_W-OFFSET_W-1:0]   resPfn,
  output logic [ADDR_W-1:0]            resFaultAddr
);

  localparam int FRAME_W  = ADDR_W - OFFSET_W;
  localparam int ROOT_LSB = OFFSET_W + IDX_W;

  logic [ADDR_W-1:0]  vaQ;
  logic [ADDR_W-1:0]  baseQ;
  logic [FRAME_W-1:0] tblFrameQ;
  logic [FRAME_W-1:0] pfnQ;
  logic               faultQ;
  logic               levelQ;

  logic [IDX_W-1:0]   rootIdx;
  logic [IDX_W-1:0]   leafIdx;
  logic [ADDR_W-1:0]  rootEntryAddr;
  logic [ADDR_W-1:0]  leafEntryAddr;
  logic [FRAME_W-1:0] rspFrame;
  logic               unusedRspFlags;

  // Field extraction of the latched virtual address.
  assign rootIdx = vaQ[ROOT_LSB +: IDX_W];
  assign leafIdx = vaQ[OFFSET_W +: IDX_W];

  // Entry addresses: table base plus index scaled by the entry size.
  assign rootEntryAddr = baseQ + (ADDR_W'(rootIdx) << ENTRY_LOG2);
  assign leafEntryAddr = {tblFrameQ, {OFFSET_W{1'b0}}}
                       | (ADDR_W'(leafIdx) << ENTRY_LOG2);

  assign memReqAddr = strb.selLeaf ? leafEntryAddr : rootEntryAddr;

  // Entry decode.
  assign rspFrame       = memRspData[ADDR_W-1:OFFSET_W];
  assign entryPresent   = memRspData[PRESENT_BIT];
  assign unusedRspFlags = ^memRspData[OFFSET_W-1:PRESENT_BIT+1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ       <= '0;
      baseQ     <= '0;
      tblFrameQ <= '0;
      pfnQ      <= '0;
      faultQ    <= 1'b0;
      levelQ    <= 1'b0;
    end else begin
      if (strb.capReq) begin
        vaQ    <= walkVaddr;
        baseQ  <= rootBase;
        pfnQ   <= '0;
        faultQ <= 1'b0;
        levelQ <= 1'b0;
      end
      if (strb.capTable) tblFrameQ <= rspFrame;
      if (strb.capLeaf)  pfnQ      <= rspFrame;
      if (strb.faultRoot) begin
        faultQ <= 1'b1;
        levelQ <= 1'b0;
      end
      if (strb.faultLeaf) begin
        faultQ <= 1'b1;
        levelQ <= 1'b1;
      end
    end
  end

  assign resFault     = faultQ;
  assign resLevel     = levelQ;
  assign resVpn       = vaQ[ADDR_W-1:OFFSET_W];
  assign resPfn       = pfnQ;
  assign resFaultAddr = vaQ;

endmodule

// File: rtl/ptw_control.sv
module ptw_control
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        walkValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        entryPresent,
  output logic        walkReady,
  output logic        memReqValid,
  output logic        resValid,
  output ptwStrobes_t strb
);

  walkState_t stateQ, stateD;
  logic       waitQ, waitD;   // a read has been accepted and awaits data

  always_comb begin
    stateD      = stateQ;
    waitD       = waitQ;
    strb        = '0;
    walkReady   = 1'b0;
    memReqValid = 1'b0;
    resValid    = 1'b0;

    unique case (stateQ)
      WALK_IDLE: begin
        walkReady = 1'b1;
        if (walkValid) begin
          strb.capReq = 1'b1;
          stateD      = WALK_ROOT;
        end
      end

      WALK_ROOT: begin
        strb.selLeaf = 1'b0;
        memReqValid  = !waitQ;
        if (!waitQ && memReqReady) waitD = 1'b1;
        if (waitQ && memRspValid) begin
          waitD = 1'b0;
          if (entryPresent) begin
            strb.capTable = 1'b1;
            stateD        = WALK_LEAF;
          end else begin
            strb.faultRoot = 1'b1;
            stateD         = WALK_REPORT;
          end
        end
      end

      WALK_LEAF: begin
        strb.selLeaf = 1'b1;
        memReqValid  = !waitQ;
        if (!waitQ && memReqReady) waitD = 1'b1;
        if (waitQ && memRspValid) begin
          waitD = 1'b0;
          if (entryPresent) strb.capLeaf   = 1'b1;
          else              strb.faultLeaf = 1'b1;
          stateD = WALK_REPORT;
        end
      end

      WALK_REPORT: begin
        resValid = 1'b1;
        stateD   = WALK_IDLE;
      end

      default: stateD = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= WALK_IDLE;
      waitQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      waitQ  <= waitD;
    end
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int ADDR_W     = 32,
  parameter int OFFSET_W   = 12,
  parameter int IDX_W      = 10,
  parameter int ENTRY_LOG2 = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       walkValid,
  output logic                       walkReady,
  input  logic [ADDR_W-1:0]          walkVaddr,
  input  logic [ADDR_W-1:0]          rootBase,
  output logic                       memReqValid,
  input  logic                       memReqReady,
  output logic [ADDR_W-1:0]          memReqAddr,
  input  logic                       memRspValid,
  input  logic [ADDR_W-1:0]          memRspData,
  output logic                       resValid,
  output logic                       resFault,
  output logic                       resLevel,
  output logic [ADDR_W-OFFSET_W-1:0] resVpn,
  output logic [ADDR_W-OFFSET_W-1:0] resPfn,
  output logic [ADDR_W-1:0]          resFaultAddr
);

  ptw_pkg::ptwStrobes_t strb;
  logic                 entryPresent;

  ptw_control u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .walkValid    (walkValid),
    .memReqReady  (memReqReady),
    .memRspValid  (memRspValid),
    .entryPresent (entryPresent),
    .walkReady    (walkReady),
    .memReqValid  (memReqValid),
    .resValid     (resValid),
    .strb         (strb)
  );

  ptw_datapath #(
    .ADDR_W     (ADDR_W),
    .OFFSET_W   (OFFSET_W),
    .IDX_W      (IDX_W),
    .ENTRY_LOG2 (ENTRY_LOG2)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .walkVaddr    (walkVaddr),
    .rootBase     (rootBase),
    .memRspData   (memRspData),
    .memReqAddr   (memReqAddr),
    .entryPresent (entryPresent),
    .resFault     (resFault),
    .resLevel     (resLevel),
    .resVpn       (resVpn),
    .resPfn       (resPfn),
    .resFaultAddr (resFaultAddr)
  );

endmodule

// File: rtl/pt_walker_checker.sv
module pt_walker_checker #(
  parameter int ADDR_W     = 32,
  parameter int OFFSET_W   = 12,
  parameter int IDX_W      = 10,
  parameter int ENTRY_LOG2 = 2
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       walkValid,
  input logic                       walkReady,
  input logic [ADDR_W-1:0]          walkVaddr,
  input logic [ADDR_W-1:0]          rootBase,
  input logic                       memReqValid,
  input logic                       memReqReady,
  input logic [ADDR_W-1:0]          memReqAddr,
  input logic                       memRspValid,
  input logic [ADDR_W-1:0]          memRspData,
  input logic                       resValid,
  input logic                       resFault,
  input logic                       resLevel,
  input logic [ADDR_W-OFFSET_W-1:0] resVpn,
  input logic [ADDR_W-OFFSET_W-1:0] resPfn,
  input logic [ADDR_W-1:0]          resFaultAddr
);

  localparam int FRAME_W = ADDR_W - OFFSET_W;

  logic [ADDR_W-1:0]  seenVa;
  logic [ADDR_W-1:0]  seenBase;
  logic [FRAME_W-1:0] seenTable;
  logic [1:0]         reqNo;
  logic               outstanding;
  logic               unusedChk;

  assign unusedChk = ^{memRspData[OFFSET_W-1:0], resPfn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenVa      <= '0;
      seenBase    <= '0;
      seenTable   <= '0;
      reqNo       <= '0;
      outstanding <= 1'b0;
    end else begin
      if (walkValid && walkReady) begin
        seenVa   <= walkVaddr;
        seenBase <= rootBase;
        reqNo    <= '0;
      end else if (memReqValid && memReqReady) begin
        reqNo <= reqNo + 2'd1;
      end
      if (memReqValid && memReqReady) outstanding <= 1'b1;
      else if (memRspValid)           outstanding <= 1'b0;
      if (memRspValid && outstanding && reqNo == 2'd1)
        seenTable <= memRspData[ADDR_W-1:OFFSET_W];
    end
  end

  a_r2_root_addr: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && reqNo == 2'd0 |->
      memReqAddr == seenBase + (ADDR_W'(seenVa[OFFSET_W+IDX_W +: IDX_W]) << ENTRY_LOG2));

  a_r3_leaf_addr: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && reqNo == 2'd1 |->
      memReqAddr == ({seenTable, {OFFSET_W{1'b0}}}
                     | (ADDR_W'(seenVa[OFFSET_W +: IDX_W]) << ENTRY_LOG2)));

  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  a_r4_single_read: assert property (@(posedge clk) disable iff (!rstN)
    outstanding |-> !memReqValid);

  a_r5_root_fault_one_read: assert property (@(posedge clk) disable iff (!rstN)
    resValid && resFault && !resLevel |-> reqNo == 2'd1);

  a_r6_two_reads: assert property (@(posedge clk) disable iff (!rstN)
    resValid && (resLevel || !resFault) |-> reqNo == 2'd2);

  a_r8_result_addr: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> resFaultAddr == seenVa && resVpn == seenVa[ADDR_W-1:OFFSET_W]);

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    walkReady |-> !memReqValid && !resValid);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

endmodule

bind pt_walker pt_walker_checker #(
  .ADDR_W     (ADDR_W),
  .OFFSET_W   (OFFSET_W),
  .IDX_W      (IDX_W),
  .ENTRY_LOG2 (ENTRY_LOG2)
) chk (
  .clk          (clk),
  .rstN         (rstN),
  .walkValid    (walkValid),
  .walkReady    (walkReady),
  .walkVaddr    (walkVaddr),
  .rootBase     (rootBase),
  .memReqValid  (memReqValid),
  .memReqReady  (memReqReady),
  .memReqAddr   (memReqAddr),
  .memRspValid  (memRspValid),
  .memRspData   (memRspData),
  .resValid     (resValid),
  .resFault     (resFault),
  .resLevel     (resLevel),
  .resVpn       (resVpn),
  .resPfn       (resPfn),
  .resFaultAddr (resFaultAddr)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        walkValid = 1'b0;
  logic        walkReady;
  logic [31:0] walkVaddr = '0;
  logic [31:0] rootBase = '0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        resValid;
  logic        resFault;
  logic        resLevel;
  logic [19:0] resVpn;
  logic [19:0] resPfn;
  logic [31:0] resFaultAddr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;   // 50 MHz

  pt_walker uut (
    .clk(clk), .rstN(rstN),
    .walkValid(walkValid), .walkReady(walkReady), .walkVaddr(walkVaddr),
    .rootBase(rootBase),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .resValid(resValid), .resFault(resFault), .resLevel(resLevel),
    .resVpn(resVpn), .resPfn(resPfn), .resFaultAddr(resFaultAddr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---- table contents, computed arithmetically ----
  logic [31:0] curBase;
  int          stallCfg = 0;
  int          latCfg = 1;

  function automatic bit rootPresent(input int i);
    return (i % 4) != 3;
  endfunction
  function automatic bit leafPresent(input int i, input int j);
    return ((i + j) % 5) != 4;
  endfunction
  function automatic logic [19:0] leafPfn(input int i, input int j);
    return 20'((i * 37 + j * 11 + 5) & 32'hFFFFF);
  endfunction
  function automatic logic [19:0] tableFrame(input int i);
    return 20'h80000 | 20'(i);
  endfunction

  // Flag bits 11:1 are filled with noise that the walker must ignore.
  function automatic logic [31:0] memWord(input logic [31:0] a);
    int i, j;
    if (a[31]) begin
      i = int'(a[21:12]);
      j = int'(a[11:2]);
      return {leafPfn(i, j), 11'h155, leafPresent(i, j)};
    end
    i = int'((a - curBase) >> 2);
    return {tableFrame(i), 11'h2AA, rootPresent(i)};
  endfunction

  // ---- memory model ----
  logic [31:0] expAddr1, expAddr2;
  int          reqInWalk = 0;

  initial begin
    bit          readyPrev = 0, outst = 0, held = 0;
    int          cntdown = 0, waitCnt = 0;
    logic [31:0] heldAddr = '0, pendAddr = '0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      memReqReady = 1'b0;
      if (readyPrev) begin
        readyPrev = 0; outst = 1; held = 0; cntdown = latCfg;
      end
      if (outst) begin
        if (memReqValid) check(0, "R4", "request while read outstanding", 32'd1, 32'd0);
        cntdown--;
        if (cntdown == 0) begin
          memRspValid = 1'b1;
          memRspData  = memWord(pendAddr);
          outst = 0;
        end
      end else if (memReqValid) begin
        if (!held) begin
          held = 1; heldAddr = memReqAddr; waitCnt = stallCfg;
          reqInWalk++;
          if (reqInWalk == 1)
            check(memReqAddr == expAddr1, "R2", "root entry address", memReqAddr, expAddr1);
          else
            check(memReqAddr == expAddr2, "R3", "leaf entry address", memReqAddr, expAddr2);
        end else if (memReqAddr != heldAddr) begin
          check(0, "R4", "address changed while stalled", memReqAddr, heldAddr);
        end
        if (waitCnt == 0) begin
          memReqReady = 1'b1; readyPrev = 1; pendAddr = heldAddr;
        end else begin
          waitCnt--;
        end
      end
    end
  end

  // ---- one walk ----
  task automatic doWalk(input logic [31:0] base, input logic [31:0] va, input bit distract);
    int  i = int'(va[31:22]);
    int  j = int'(va[21:12]);
    bit  seen = 0;
    bit  expFault;
    bit  expLevel;
    int  expReqs;
    logic [19:0] expPfn;
    curBase   = base;
    reqInWalk = 0;
    expAddr1  = base + 32'(i * 4);
    expAddr2  = {tableFrame(i), 12'h000} | 32'(j * 4);
    if (!rootPresent(i))        begin expFault = 1; expLevel = 0; expReqs = 1; expPfn = '0; end
    else if (!leafPresent(i,j)) begin expFault = 1; expLevel = 1; expReqs = 2; expPfn = '0; end
    else                        begin expFault = 0; expLevel = 0; expReqs = 2; expPfn = leafPfn(i, j); end

    @(negedge clk);
    walkVaddr = va; rootBase = base; walkValid = 1'b1;
    @(negedge clk);
    walkValid = distract;
    walkVaddr = va ^ 32'hFFFF_F000;
    rootBase  = base ^ 32'h0000_0100;
    for (int cyc = 0; cyc < 200; cyc++) begin
      if (resValid) begin seen = 1; break; end
      if (distract && cyc < 2)
        check(walkReady == 1'b0, "R9", "ready during walk", 32'(walkReady), 32'd0);
      if (cyc == 1) walkValid = 1'b0;
      @(negedge clk);
    end
    walkValid = 1'b0;
    check(seen, "R10", "result pulse seen", 32'(seen), 32'd1);
    if (seen) begin
      check(resFault == expFault, expFault ? (expLevel ? "R6" : "R5") : "R7",
            "fault flag", 32'(resFault), 32'(expFault));
      if (expFault)
        check(resLevel == expLevel, expLevel ? "R6" : "R5", "fault level",
              32'(resLevel), 32'(expLevel));
      else
        check(resPfn == expPfn, "R7", "frame number", 32'(resPfn), 32'(expPfn));
      check(reqInWalk == expReqs, expLevel || !expFault ? "R6" : "R5",
            "reads per walk", 32'(reqInWalk), 32'(expReqs));
      check(resVpn == va[31:12], distract ? "R9" : "R8", "virtual page",
            32'(resVpn), 32'(va[31:12]));
      check(resFaultAddr == va, "R8", "fault address", resFaultAddr, va);
      @(negedge clk);
      check(resValid == 1'b0, "R10", "pulse one cycle", 32'(resValid), 32'd0);
    end
  endtask

  // ---- watchdog ----
  initial begin
    repeat (150000) @(posedge clk);
    check(0, "WATCHDOG", "run hung", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---- main sequence ----
  initial begin
    int rootIdx[8] = '{0, 1, 2, 3, 511, 766, 1022, 1023};
    int leafIdx[6] = '{0, 1, 3, 512, 1022, 1023};
    logic [31:0] bases[2] = '{32'h0000_1000, 32'h0040_0000};
    int n = 0;
    curBase = bases[0];
    expAddr1 = '0; expAddr2 = '0;
    repeat (3) @(negedge clk);
    check(walkReady == 1'b1,   "R1", "ready in reset",   32'(walkReady), 32'd1);
    check(memReqValid == 1'b0, "R1", "no read in reset", 32'(memReqValid), 32'd0);
    check(resValid == 1'b0,    "R1", "no result in reset", 32'(resValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(walkReady == 1'b1,   "R1", "idle after reset",  32'(walkReady), 32'd1);
    check(memReqValid == 1'b0, "R1", "quiet after reset", 32'(memReqValid), 32'd0);

    foreach (bases[b])
      foreach (rootIdx[ri])
        foreach (leafIdx[li]) begin
          logic [31:0] va;
          va = {10'(rootIdx[ri]), 10'(leafIdx[li]), 12'(n * 97)};
          stallCfg = n % 3;
          latCfg   = 1 + (n % 4);
          doWalk(bases[b], va, (n % 3) == 1);
          n++;
        end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule